// File: doc/BRIEF.md
# Fast System-Call Entry Unit

This block computes the architectural state change that a fast system-call instruction causes. It takes a single-cycle request along with the pointer to the next instruction, the current flags word, the extended-feature enable bit, the mode bits of the caller and the entry-point and mask registers. One cycle later it presents the new instruction pointer, the return address and saved flags for the general registers, the updated flags, and the code and stack selectors with their cached attributes. It also raises a one-cycle done strobe. If the feature is disabled, it raises a one-cycle invalid-opcode strobe instead and leaves every value unchanged.

There are two entry paths. The long-mode path saves the full return address and the flags, clears the flags selected by the mask register and jumps to one of two entry registers. The legacy path truncates to 32 bits, clears a fixed set of flags and jumps to the low half of the legacy target register. The surrounding core does the register-file writes and decides what to do with the fault. It treats the values as valid only during the done strobe.

Top module: `sysc_entry`

## Requirements
- R1: After reset, every output is zero.
- R2: An accepted request with `sce_en` low produces `ud_fault` high for exactly one cycle and `call_done` low. Every value output keeps the value it had before the request.
- R3: `cs_sel` is `tgt_legacy[47:32]` with bits 1:0 forced to 0. `ss_sel` is `tgt_legacy[47:32] + 8`, taken modulo 2^16, with bits 1:0 forced to 0.
- R4: In long mode (`long_act` high), `ret_ip` is `nxt_ip` at full width, `sav_flags` is `flags_in` with bit 16 (resume) cleared, and `sav_flags_vld` is 1.
- R5: In long mode, `new_flags` is `flags_in & ~flag_clr_mask` with bit 16 also cleared.
- R6: In long mode, `new_ip` is `tgt_long64` when `code64` is high and `tgt_compat` otherwise.
- R7: In legacy mode, `ret_ip` is the low 32 bits of `nxt_ip`, zero-extended. `new_flags` is `flags_in` with bits 9 (interrupt enable), 16 (resume) and 17 (virtual-8086) cleared, and `flag_clr_mask` has no effect. `sav_flags_vld` is 0 and `sav_flags` keeps its previous value.
- R8: In legacy mode, `new_ip` is `tgt_legacy[31:0]`, zero-extended.
- R9: After a successful call, `seg_limit` is 0xFFFFFFFF. Both segments have base 0. The attribute bytes use this layout: bit0 present, bit1 granular, bit2 accessed, bit3 code, bit4 readable, bit5 writable, bit6 default-size/big, bit7 long. This gives `cs_attr` = 0x9F in long mode and 0x5F in legacy mode, and `ss_attr` = 0x67 in both modes.
- R10: All outputs update on the clock edge that samples the request. `call_done` is high for exactly that one following cycle. `call_done` and `ud_fault` are never high together.
- R11: A request sampled while `call_done` or `ud_fault` is high is ignored. No strobe follows it and no output changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| call_req | input | 1 | Request pulse |
| nxt_ip | input | AW (64) | Address of the next instruction |
| flags_in | input | FW (32) | Current flags word |
| sce_en | input | 1 | System-call feature enable |
| long_act | input | 1 | Long mode active |
| code64 | input | 1 | Caller runs 64-bit code |
| tgt_legacy | input | AW (64) | Selector field [47:32] and legacy entry [31:0] |
| tgt_long64 | input | AW (64) | Entry point for 64-bit callers |
| tgt_compat | input | AW (64) | Entry point for compatibility callers |
| flag_clr_mask | input | FW (32) | Flags to clear in long mode |
| call_done | output | 1 | One-cycle completion strobe |
| ud_fault | output | 1 | One-cycle invalid-opcode strobe |
| new_ip | output | AW (64) | New instruction pointer |
| ret_ip | output | AW (64) | Return address for the counter register |
| sav_flags | output | FW (32) | Flags to save (long mode) |
| sav_flags_vld | output | 1 | `sav_flags` is to be written |
| new_flags | output | FW (32) | Updated flags |
| cs_sel | output | 16 | Code selector |
| ss_sel | output | 16 | Stack selector |
| cs_attr | output | 8 | Code segment attributes |
| ss_attr | output | 8 | Stack segment attributes |
| seg_limit | output | 32 | Flat limit of both segments |

## Verification
The hardest situations to reach are a second request that lands while the first is still being presented, and a disabled call that follows a successful one. The bench holds the request high for two cycles and changes every data input between them. It then checks that the outputs still show the first call. It also issues disabled calls right after successful ones, so that "unchanged" means non-zero values that must survive. A directed selector value near the top of the 16-bit range makes the stack selector wrap.

// File: rtl/sysc_pkg.sv
package sysc_pkg;

  // flag bit positions touched by the entry paths
  localparam int IF_BIT = 9;
  localparam int RF_BIT = 16;
  localparam int VM_BIT = 17;

  localparam int SEL_W      = 16;
  localparam int SEL_LSB    = 32;
  localparam int SEL_STRIDE = 8;
  localparam int LIM_W      = 32;
  localparam int LEG_W      = 32;

  // cached segment attribute byte, msb first
  typedef struct packed {
    logic lng;
    logic dflt;
    logic wr;
    logic rd;
    logic code;
    logic acc;
    logic gran;
    logic pres;
  } seg_attr_t;

  function automatic seg_attr_t make_attr(input logic is_code, input logic long_mode);
    seg_attr_t a;
    a.pres = 1'b1;
    a.gran = 1'b1;
    a.acc  = 1'b1;
    a.code = is_code;
    a.rd   = is_code;
    a.wr   = !is_code;
    a.lng  = is_code && long_mode;
    a.dflt = is_code ? !long_mode : 1'b1;
    return a;
  endfunction

endpackage

// File: rtl/sysc_flag_unit.sv
module sysc_flag_unit #(
  parameter int FW = 32
) (
  input  logic [FW-1:0] flags_in,
  input  logic [FW-1:0] clr_mask,
  input  logic          long_mode,
  output logic [FW-1:0] flags_new,
  output logic [FW-1:0] flags_saved
);
  import sysc_pkg::*;

  logic [FW-1:0] rf_only;
  logic [FW-1:0] legacy_clr;

  always_comb begin
    rf_only          = '0;
    rf_only[RF_BIT]  = 1'b1;
    legacy_clr       = rf_only;
    legacy_clr[IF_BIT] = 1'b1;
    legacy_clr[VM_BIT] = 1'b1;
  end

  assign flags_saved = flags_in & ~rf_only;
  assign flags_new   = long_mode ? (flags_in & ~(clr_mask | rf_only))
                                 : (flags_in & ~legacy_clr);

endmodule

// File: rtl/sysc_target_sel.sv
module sysc_target_sel #(
  parameter int AW = 64
) (
  input  logic                       long_mode,
  input  logic                       is_code64,
  input  logic [AW-1:0]              next_ip,
  input  logic [sysc_pkg::LEG_W-1:0] leg_target,
  input  logic [AW-1:0]              long64_target,
  input  logic [AW-1:0]              compat_target,
  output logic [AW-1:0]              entry_ip,
  output logic [AW-1:0]              return_ip
);
  import sysc_pkg::*;

  logic [AW-1:0] long_entry;
  logic [AW-1:0] leg_entry;
  logic [AW-1:0] leg_return;

  assign long_entry = is_code64 ? long64_target : compat_target;
  assign leg_entry  = AW'(leg_target);
  assign leg_return = AW'(next_ip[LEG_W-1:0]);

  assign entry_ip  = long_mode ? long_entry : leg_entry;
  assign return_ip = long_mode ? next_ip : leg_return;

endmodule

// File: rtl/sysc_seg_unit.sv
module sysc_seg_unit (
  input  logic [sysc_pkg::SEL_W-1:0] sel_field,
  input  logic                       long_mode,
  output logic [sysc_pkg::SEL_W-1:0] code_sel,
  output logic [sysc_pkg::SEL_W-1:0] stack_sel,
  output logic [7:0]                 code_attr,
  output logic [7:0]                 stack_attr
);
  import sysc_pkg::*;

  localparam int NSEG = 2;

  logic [SEL_W-1:0] sel_arr  [NSEG];
  logic [7:0]       attr_arr [NSEG];

  for (genvar g = 0; g < NSEG; g++) begin : g_seg
    logic [SEL_W-1:0] raw;
    assign raw         = sel_field + SEL_W'(g * SEL_STRIDE);
    assign sel_arr[g]  = {raw[SEL_W-1:2], 2'b00};
    assign attr_arr[g] = make_attr((g == 0), long_mode);
  end

  assign code_sel   = sel_arr[0];
  assign stack_sel  = sel_arr[1];
  assign code_attr  = attr_arr[0];
  assign stack_attr = attr_arr[1];

endmodule

// File: rtl/sysc_entry.sv
module sysc_entry #(
  parameter int AW = 64,
  parameter int FW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          call_req,
  input  logic [AW-1:0] nxt_ip,
  input  logic [FW-1:0] flags_in,
  input  logic          sce_en,
  input  logic          long_act,
  input  logic          code64,
  input  logic [AW-1:0] tgt_legacy,
  input  logic [AW-1:0] tgt_long64,
  input  logic [AW-1:0] tgt_compat,
  input  logic [FW-1:0] flag_clr_mask,
  output logic          call_done,
  output logic          ud_fault,
  output logic [AW-1:0] new_ip,
  output logic [AW-1:0] ret_ip,
  output logic [FW-1:0] sav_flags,
  output logic          sav_flags_vld,
  output logic [FW-1:0] new_flags,
  output logic [15:0]   cs_sel,
  output logic [15:0]   ss_sel,
  output logic [7:0]    cs_attr,
  output logic [7:0]    ss_attr,
  output logic [31:0]   seg_limit
);
  import sysc_pkg::*;

  localparam logic [LIM_W-1:0] FLAT_LIMIT = '1;

  logic          accept;
  logic          take;
  logic [FW-1:0] flags_nx;
  logic [FW-1:0] flags_sv;
  logic [AW-1:0] ip_nx;
  logic [AW-1:0] ret_nx;
  logic [15:0]   cs_nx;
  logic [15:0]   ss_nx;
  logic [7:0]    csa_nx;
  logic [7:0]    ssa_nx;

  sysc_flag_unit #(.FW(FW)) u_flags (
    .flags_in    (flags_in),
    .clr_mask    (flag_clr_mask),
    .long_mode   (long_act),
    .flags_new   (flags_nx),
    .flags_saved (flags_sv)
  );

  sysc_target_sel #(.AW(AW)) u_target (
    .long_mode     (long_act),
    .is_code64     (code64),
    .next_ip       (nxt_ip),
    .leg_target    (tgt_legacy[LEG_W-1:0]),
    .long64_target (tgt_long64),
    .compat_target (tgt_compat),
    .entry_ip      (ip_nx),
    .return_ip     (ret_nx)
  );

  sysc_seg_unit u_seg (
    .sel_field  (tgt_legacy[SEL_LSB+SEL_W-1:SEL_LSB]),
    .long_mode  (long_act),
    .code_sel   (cs_nx),
    .stack_sel  (ss_nx),
    .code_attr  (csa_nx),
    .stack_attr (ssa_nx)
  );

  // a request is only taken when no strobe is being presented
  assign accept = call_req && !call_done && !ud_fault;
  assign take   = accept && sce_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      call_done     <= 1'b0;
      ud_fault      <= 1'b0;
      new_ip        <= '0;
      ret_ip        <= '0;
      sav_flags     <= '0;
      sav_flags_vld <= 1'b0;
      new_flags     <= '0;
      cs_sel        <= '0;
      ss_sel        <= '0;
      cs_attr       <= '0;
      ss_attr       <= '0;
      seg_limit     <= '0;
    end else begin
      call_done <= take;
      ud_fault  <= accept && !sce_en;
      if (take) begin
        new_ip        <= ip_nx;
        ret_ip        <= ret_nx;
        new_flags     <= flags_nx;
        sav_flags_vld <= long_act;
        if (long_act) sav_flags <= flags_sv;
        cs_sel        <= cs_nx;
        ss_sel        <= ss_nx;
        cs_attr       <= csa_nx;
        ss_attr       <= ssa_nx;
        seg_limit     <= FLAT_LIMIT;
      end
    end
  end

  // R10
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(call_done && ud_fault));

  // R10
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    call_done |=> !call_done);

  // R10
  done_cause_chk: assert property (@(posedge clk) disable iff (rst)
    call_done |-> ($past(call_req) && $past(sce_en)));

  // R2
  fault_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ud_fault |-> ($stable(new_ip) && $stable(ret_ip) && $stable(new_flags) &&
                  $stable(cs_sel) && $stable(ss_sel) && $stable(sav_flags)));

  // R3
  sel_pair_chk: assert property (@(posedge clk) disable iff (rst)
    call_done |-> (cs_sel[1:0] == 2'b00 && ss_sel == cs_sel + 16'd8));

  // R9
  attr_mode_chk: assert property (@(posedge clk) disable iff (rst)
    call_done |-> (cs_attr[7] != cs_attr[6] && cs_attr[7] == sav_flags_vld));

  // R11
  busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (call_done || ud_fault) |=> (!call_done && !ud_fault));

endmodule

// File: tb/sysc_entry_tb.sv
module sysc_entry_tb;
  localparam int AW = 64;
  localparam int FW = 32;

  logic          clk = 1'b0;
  logic          rst;
  logic          call_req;
  logic [AW-1:0] nxt_ip;
  logic [FW-1:0] flags_in;
  logic          sce_en;
  logic          long_act;
  logic          code64;
  logic [AW-1:0] tgt_legacy;
  logic [AW-1:0] tgt_long64;
  logic [AW-1:0] tgt_compat;
  logic [FW-1:0] flag_clr_mask;
  logic          call_done;
  logic          ud_fault;
  logic [AW-1:0] new_ip;
  logic [AW-1:0] ret_ip;
  logic [FW-1:0] sav_flags;
  logic          sav_flags_vld;
  logic [FW-1:0] new_flags;
  logic [15:0]   cs_sel;
  logic [15:0]   ss_sel;
  logic [7:0]    cs_attr;
  logic [7:0]    ss_attr;
  logic [31:0]   seg_limit;

  int checks = 0;
  int failures = 0;

  // model state: last successfully written values
  logic [AW-1:0] m_ip, m_ret;
  logic [FW-1:0] m_sflags, m_nflags;
  logic          m_svld;
  logic [15:0]   m_cs, m_ss;
  logic [7:0]    m_csa, m_ssa;
  logic [31:0]   m_lim;

  always #2.5 clk = ~clk;

  sysc_entry #(.AW(AW), .FW(FW)) u_dut (
    .clk(clk), .rst(rst), .call_req(call_req), .nxt_ip(nxt_ip),
    .flags_in(flags_in), .sce_en(sce_en), .long_act(long_act), .code64(code64),
    .tgt_legacy(tgt_legacy), .tgt_long64(tgt_long64), .tgt_compat(tgt_compat),
    .flag_clr_mask(flag_clr_mask), .call_done(call_done), .ud_fault(ud_fault),
    .new_ip(new_ip), .ret_ip(ret_ip), .sav_flags(sav_flags),
    .sav_flags_vld(sav_flags_vld), .new_flags(new_flags), .cs_sel(cs_sel),
    .ss_sel(ss_sel), .cs_attr(cs_attr), .ss_attr(ss_attr), .seg_limit(seg_limit)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] r64();
    return {$urandom(), $urandom()};
  endfunction

  // update the model from the current inputs (successful call)
  task automatic model_call();
    logic [15:0] f;
    f = tgt_legacy[47:32];
    m_cs  = f & 16'hFFFC;
    m_ss  = (f + 16'd8) & 16'hFFFC;
    m_ssa = 8'h67;
    m_lim = 32'hFFFF_FFFF;
    if (long_act) begin
      m_ret    = nxt_ip;
      m_sflags = flags_in & ~(32'h1 << 16);
      m_svld   = 1'b1;
      m_nflags = flags_in & ~flag_clr_mask & ~(32'h1 << 16);
      m_ip     = code64 ? tgt_long64 : tgt_compat;
      m_csa    = 8'h9F;
    end else begin
      m_ret    = {32'h0, nxt_ip[31:0]};
      m_svld   = 1'b0;
      m_nflags = flags_in & ~((32'h1 << 9) | (32'h1 << 16) | (32'h1 << 17));
      m_ip     = {32'h0, tgt_legacy[31:0]};
      m_csa    = 8'h5F;
    end
  endtask

  task automatic cmp_state();
    chk(long_act ? "R6 new_ip long" : "R8 new_ip legacy", new_ip, m_ip);
    chk(long_act ? "R4 ret_ip long" : "R7 ret_ip legacy", ret_ip, m_ret);
    chk("R4 R7 sav_flags", 64'(sav_flags), 64'(m_sflags));
    chk("R4 R7 sav_flags_vld", 64'(sav_flags_vld), 64'(m_svld));
    chk(long_act ? "R5 new_flags long" : "R7 new_flags legacy", 64'(new_flags), 64'(m_nflags));
    chk("R3 cs_sel", 64'(cs_sel), 64'(m_cs));
    chk("R3 ss_sel", 64'(ss_sel), 64'(m_ss));
    chk("R9 cs_attr", 64'(cs_attr), 64'(m_csa));
    chk("R9 ss_attr", 64'(ss_attr), 64'(m_ssa));
    chk("R9 seg_limit", 64'(seg_limit), 64'(m_lim));
  endtask

  task automatic randomize_inputs();
    nxt_ip        = r64();
    flags_in      = $urandom();
    long_act      = $urandom() % 2 == 1;
    code64        = $urandom() % 2 == 1;
    tgt_legacy    = r64();
    tgt_long64    = r64();
    tgt_compat    = r64();
    flag_clr_mask = $urandom();
  endtask

  // one request; inputs are already set at entry
  task automatic issue_call();
    @(negedge clk);
    chk("R10 idle before request done", 64'(call_done), 64'd0);
    call_req = 1'b1;
    @(negedge clk);
    call_req = 1'b0;
    if (sce_en) begin
      model_call();
      chk("R10 done pulse", 64'(call_done), 64'd1);
      chk("R10 no fault with done", 64'(ud_fault), 64'd0);
    end else begin
      chk("R2 fault pulse", 64'(ud_fault), 64'd1);
      chk("R2 no done on fault", 64'(call_done), 64'd0);
    end
    cmp_state();
    @(negedge clk);
    chk("R10 done one cycle", 64'(call_done), 64'd0);
    chk("R2 fault one cycle", 64'(ud_fault), 64'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL R10 watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1; call_req = 1'b0; sce_en = 1'b1;
    randomize_inputs();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 done reset", 64'(call_done), 64'd0);
    chk("R1 fault reset", 64'(ud_fault), 64'd0);
    chk("R1 new_ip reset", new_ip, 64'd0);
    chk("R1 ret_ip reset", ret_ip, 64'd0);
    chk("R1 flags reset", 64'(new_flags) | 64'(sav_flags) | 64'(sav_flags_vld), 64'd0);
    chk("R1 seg reset", {cs_sel, ss_sel, cs_attr, ss_attr, seg_limit[15:0]}, 64'd0);
    m_ip = '0; m_ret = '0; m_sflags = '0; m_nflags = '0; m_svld = 1'b0;
    m_cs = '0; m_ss = '0; m_csa = '0; m_ssa = '0; m_lim = '0;

    // R2 disabled call straight out of reset: everything stays zero
    sce_en = 1'b0;
    issue_call();

    // directed long mode, 64-bit caller, selector wraps (R3 R5 R6)
    sce_en = 1'b1; long_act = 1'b1; code64 = 1'b1;
    flags_in = 32'hFFFF_FFFF; flag_clr_mask = 32'h0000_0F00;
    tgt_legacy = {16'h0, 16'hFFFB, 32'h1234_5678};
    issue_call();

    // directed long mode, compat caller (R6)
    code64 = 1'b0; flag_clr_mask = 32'h0;
    issue_call();

    // directed legacy: mask ignored, IF/RF/VM cleared (R7 R8)
    long_act = 1'b0; flags_in = 32'hFFFF_FFFF; flag_clr_mask = 32'hFFFF_FFFF;
    nxt_ip = 64'hDEAD_BEEF_CAFE_F00D;
    issue_call();

    // R2 disabled after a successful call: non-zero state must survive
    sce_en = 1'b0; randomize_inputs();
    issue_call();

    // R11 back-to-back: second cycle of request is ignored
    sce_en = 1'b1; randomize_inputs();
    @(negedge clk);
    call_req = 1'b1;
    @(negedge clk);
    model_call();
    chk("R11 first accepted", 64'(call_done), 64'd1);
    randomize_inputs();
    long_act = !long_act;
    sce_en = 1'b0;
    @(negedge clk);
    call_req = 1'b0;
    chk("R11 second no done", 64'(call_done), 64'd0);
    chk("R11 second no fault", 64'(ud_fault), 64'd0);
    chk("R11 new_ip held", new_ip, m_ip);
    chk("R11 cs_attr held", 64'(cs_attr), 64'(m_csa));
    chk("R11 new_flags held", 64'(new_flags), 64'(m_nflags));
    sce_en = 1'b1;

    // constrained random mix
    for (int i = 0; i < 300; i++) begin
      randomize_inputs();
      sce_en = ($urandom() % 8) != 0;
      issue_call();
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule